// File: doc/BRIEF.md
# Keyed Watchdog Timer with Prescaled Basic Timer

The block guards a system against a stalled program. A free-running divider on the system clock feeds a small basic timer. The divider tap, and so the basic timer's rate, is chosen by a 4-bit mode field. Each time the basic timer wraps it emits a one-cycle overflow pulse. A 3-bit watchdog counter counts these pulses. When the counter wraps, the block raises a one-cycle reset request. Software keeps the system alive by pulsing a clear strobe often enough to stop the counter from wrapping.

The watchdog can only be switched off by writing one exact key byte (5AH) to the 8-bit write-only mode register. Every other byte switches it on. The register comes out of reset holding A5H, so the watchdog runs from power-up. The basic timer also comes out of reset on its slowest tap, which gives the longest interval. One full watchdog interval is 2^3 × 2^BT_W × 2^n system clocks, where n is the selected tap. Entry into stop or wait mode keeps the watchdog counter at zero.

Top module: `keyed_wdt`

## Requirements
- R1: After reset, rst_req and bt_ovf are 0, bt_cnt is 0, the watchdog is enabled, and the basic timer advances once every 4096 clocks (the slowest tap, 2^12).
- R2: Bits 2..0 of the basic-timer mode field select the tap: 000 gives 2^12, 011 gives 2^9, 101 gives 2^7 and 111 gives 2^5 clocks per bt_cnt step. Bit 3 is ignored.
- R3: Any other value of bits 2..0 (001, 010, 100, 110) selects the 2^12 tap.
- R4: bt_ovf is high for exactly one cycle, in the cycle when bt_cnt holds its all-ones value and a step is due. bt_cnt reads 0 on the next cycle, so overflows come once every 2^BT_W steps.
- R5: While the watchdog is enabled and not held, rst_req pulses high for one cycle, in the cycle that follows the eighth bt_ovf since the watchdog counter was last zeroed.
- R6: Writing 5AH to the mode register disables the watchdog. While disabled, rst_req stays 0 and the counter is held at 0. Writing any other byte (for example 5BH) re-enables it, and counting then starts from 0.
- R7: A one-cycle wd_clear pulse zeroes the watchdog counter, so the next rst_req comes eight overflows later. If the clear lands in the same cycle as the overflow that would have fired, the clear wins and no request is made.
- R8: While stop_i or wait_i is high, the watchdog counter is held at 0 and overflows are not counted. After release, eight new overflows are needed before rst_req.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock (fxx) |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_we | input | 1 | Write strobe for the watchdog mode byte |
| mode_wdata | input | 8 | Mode byte: 5AH disables, any other value enables |
| btm_we | input | 1 | Write strobe for the basic-timer mode field |
| btm_wdata | input | 4 | Tap select; bit 3 is ignored |
| wd_clear | input | 1 | Clear strobe for the watchdog counter |
| stop_i | input | 1 | Stop-mode indication; holds the counter at 0 |
| wait_i | input | 1 | Wait-mode indication; holds the counter at 0 |
| bt_cnt | output | BT_W (8) | Basic timer count |
| bt_ovf | output | 1 | Basic timer overflow pulse |
| rst_req | output | 1 | One-cycle system reset request |

## Verification
The bench times the bt_cnt steps for every listed tap code, for codes outside the list and with bit 3 set. A wrong tap decode shows up as a step period other than the expected power of two. It counts overflow pulses between reset requests. An off-by-one in the wrap compare would fire on the seventh or ninth overflow. It also drops a clear onto the very overflow that would have fired. A design that let the overflow win would emit a request there. Finally, it writes a value one away from the key, and it holds stop and wait across several overflows. A design with a loose key compare would stay silent. A design that only froze the counter during a hold would fire early after release.

// File: rtl/keyed_wdt.sv
module keyed_wdt #(
  parameter int        BT_W      = 8,
  parameter int        WD_W      = 3,
  parameter logic [7:0] KEY      = 8'h5A,
  parameter logic [7:0] MODE_INIT = 8'hA5,
  parameter int        SH_SLOW   = 12,
  parameter int        SH_A      = 9,
  parameter int        SH_B      = 7,
  parameter int        SH_FAST   = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            mode_we,
  input  logic [7:0]      mode_wdata,
  input  logic            btm_we,
  input  logic [3:0]      btm_wdata,
  input  logic            wd_clear,
  input  logic            stop_i,
  input  logic            wait_i,
  output logic [BT_W-1:0] bt_cnt,
  output logic            bt_ovf,
  output logic            rst_req
);
  localparam int DIV_W = SH_SLOW;
  localparam logic [DIV_W-1:0] ONES = {DIV_W{1'b1}};

  logic [7:0]       mode_q;
  logic [2:0]       btm_q;
  logic [DIV_W-1:0] div;
  logic [DIV_W-1:0] tap_mask;
  logic [WD_W-1:0]  wd_cnt;
  logic             tick, wd_on, wd_hold;

  always_comb begin
    case (btm_q)
      3'b011:  tap_mask = ONES >> (DIV_W - SH_A);
      3'b101:  tap_mask = ONES >> (DIV_W - SH_B);
      3'b111:  tap_mask = ONES >> (DIV_W - SH_FAST);
      default: tap_mask = ONES;
    endcase
  end

  assign tick    = &(div | ~tap_mask);
  assign bt_ovf  = tick & (&bt_cnt);
  assign wd_on   = (mode_q != KEY);
  assign wd_hold = ~wd_on | wd_clear | stop_i | wait_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_INIT;
      btm_q  <= 3'b000;
    end else begin
      if (mode_we) mode_q <= mode_wdata;
      if (btm_we)  btm_q  <= btm_wdata[2:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div    <= '0;
      bt_cnt <= '0;
    end else begin
      div <= div + 1'b1;
      if (tick) bt_cnt <= bt_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wd_cnt  <= '0;
      rst_req <= 1'b0;
    end else begin
      if (wd_hold)     wd_cnt <= '0;
      else if (bt_ovf) wd_cnt <= wd_cnt + 1'b1;
      rst_req <= ~wd_hold & bt_ovf & (&wd_cnt);
    end
  end

  p_bt_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bt_ovf |=> (bt_cnt == '0));
  p_rst_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);
  p_rst_from_ovf_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> $past(bt_ovf));
  p_key_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> ($past(mode_q) != KEY));
  p_clear_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wd_clear |=> (wd_cnt == '0 && !rst_req));
  p_hold_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_i || wait_i) |=> (wd_cnt == '0 && !rst_req));
endmodule

// File: tb/tb_keyed_wdt.sv
module tb_keyed_wdt;
  localparam int BT_W = 3;
  logic clk = 1'b0, rst_n = 1'b0;
  logic mode_we = 0, btm_we = 0, wd_clear = 0, stop_i = 0, wait_i = 0;
  logic [7:0] mode_wdata = 0;
  logic [3:0] btm_wdata = 0;
  logic [BT_W-1:0] bt_cnt;
  logic bt_ovf, rst_req;
  int n_run = 0, n_fail = 0, cyc = 0;
  bit done = 0;

  always #4 clk = ~clk;

  keyed_wdt #(.BT_W(BT_W)) dut (.clk(clk), .rst_n(rst_n), .mode_we(mode_we),
    .mode_wdata(mode_wdata), .btm_we(btm_we), .btm_wdata(btm_wdata),
    .wd_clear(wd_clear), .stop_i(stop_i), .wait_i(wait_i),
    .bt_cnt(bt_cnt), .bt_ovf(bt_ovf), .rst_req(rst_req));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    cyc++;
  endtask

  task automatic wr_btm(input logic [3:0] v);
    btm_wdata = v; btm_we = 1; step(); btm_we = 0;
  endtask

  task automatic wr_mode(input logic [7:0] v);
    mode_wdata = v; mode_we = 1; step(); mode_we = 0;
  endtask

  task automatic t_tap(input logic [3:0] code, input int exp, input string req);
    logic [BT_W-1:0] prev;
    int n = 0;
    wr_btm(code);
    prev = bt_cnt;
    while (bt_cnt == prev && n < 5000) begin step(); n++; end
    prev = bt_cnt; n = 0;
    while (bt_cnt == prev && n < 5000) begin step(); n++; end
    chk(n == exp, req, n, exp);
  endtask

  task automatic wait_rst();
    int n = 0;
    while (!rst_req && n < 5000) begin step(); n++; end
    step();
  endtask

  task automatic ovf_to_rst(output int novf, output int ncyc);
    novf = 0; ncyc = 0;
    while (!rst_req && ncyc < 5000) begin
      if (bt_ovf) novf++;
      step(); ncyc++;
    end
  endtask

  task automatic skip_ovf(input int k);
    int s = 0;
    while (s < k) begin if (bt_ovf) s++; step(); end
  endtask

  task automatic t_reset();
    chk(rst_req == 0 && bt_ovf == 0, "R1 outputs", {rst_req, bt_ovf}, 0);
    chk(bt_cnt == 0, "R1 bt_cnt", bt_cnt, 0);
  endtask

  task automatic t_ovf();
    int n = 0;
    wr_btm(4'b0111);
    while (!bt_ovf) step();
    chk(bt_cnt == 7, "R4 count at ovf", bt_cnt, 7);
    step();
    chk(!bt_ovf && bt_cnt == 0, "R4 single pulse and wrap", bt_cnt + 8 * bt_ovf, 0);
    while (!bt_ovf) begin step(); n++; end
    chk(n + 1 == 256, "R4 ovf period", n + 1, 256);
  endtask

  task automatic t_period();
    int o, c;
    wait_rst();
    chk(!rst_req, "R5 single cycle", rst_req, 0);
    ovf_to_rst(o, c);
    chk(o == 8, "R5 ovf count", o, 8);
    chk(c + 1 == 2048, "R5 interval", c + 1, 2048);
  endtask

  task automatic t_clear();
    int o, c;
    wait_rst();
    skip_ovf(3);
    wd_clear = 1; step(); wd_clear = 0;
    ovf_to_rst(o, c);
    chk(o == 8, "R7 clear restarts", o, 8);
    step();
    o = 0;
    while (o < 8) begin
      if (bt_ovf) o++;
      if (o < 8) step();
    end
    wd_clear = 1; step(); wd_clear = 0;
    chk(!rst_req, "R7 clear beats overflow", rst_req, 0);
    ovf_to_rst(o, c);
    chk(o == 8, "R7 count after coincident clear", o, 8);
    step();
  endtask

  task automatic t_key();
    int o, c, seen = 0;
    wait_rst();
    skip_ovf(2);
    wr_mode(8'h5A);
    for (int i = 0; i < 3000; i++) begin if (rst_req) seen++; step(); end
    chk(seen == 0, "R6 disabled no request", seen, 0);
    wr_mode(8'h5B);
    ovf_to_rst(o, c);
    chk(o == 8, "R6 near-key enables from 0", o, 8);
    step();
  endtask

  task automatic t_hold(input bit use_stop, input string req);
    int o, c, seen = 0;
    wait_rst();
    skip_ovf(4);
    if (use_stop) stop_i = 1; else wait_i = 1;
    for (int i = 0; i < 3000; i++) begin if (rst_req) seen++; step(); end
    stop_i = 0; wait_i = 0;
    chk(seen == 0, req, seen, 0);
    ovf_to_rst(o, c);
    chk(o == 8, req, o, 8);
    step();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    step();
    t_reset();
    begin
      logic [BT_W-1:0] p; int n = 0;
      p = bt_cnt;
      while (bt_cnt == p) step();
      p = bt_cnt;
      while (bt_cnt == p && n < 5000) begin step(); n++; end
      chk(n == 4096, "R1 default slow tap", n, 4096);
    end
    t_tap(4'b0000, 4096, "R2 code 000");
    t_tap(4'b0011, 512,  "R2 code 011");
    t_tap(4'b0101, 128,  "R2 code 101");
    t_tap(4'b0111, 32,   "R2 code 111");
    t_tap(4'b1111, 32,   "R2 bit3 ignored");
    t_tap(4'b0001, 4096, "R3 code 001");
    t_tap(4'b0110, 4096, "R3 code 110");
    t_ovf();
    t_period();
    t_clear();
    t_key();
    t_hold(1, "R8 stop hold");
    t_hold(0, "R8 wait hold");
    done = 1;
  end

  initial begin
    while (!done && cyc < 150000) @(negedge clk);
    if (!done) chk(0, "watchdog", cyc, 150000);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule